// File: doc/BRIEF.md
# SPI Slave Byte Exchanger

This block lets a local processor talk to an external host over a four-pin SPI link in which the block is always the slave. For every byte the host clocks in on SI, exactly one byte leaves on SO, most significant bit first. The host's clock, select and data pins are brought into the system clock domain through two-flop synchronisers and their edges are found there. The system clock must run at least four times faster than SCK.

The processor sees a byte-wide receive register with a full flag, and a byte-wide transmit register with an empty flag. It also sees two sticky error flags: receive overrun and transmit underrun. An interrupt line is raised whenever any of these four conditions is present. The clock polarity comes from a strap input sampled once after reset. It is then held and reported as the mode bit. The polarity fixes which SCK edge drives SO and which SCK edge samples SI.

Top module: `spi_byte_slave`

## Requirements
- R1: After reset, rx_full=0, tx_empty=1, overrun=0, underrun=0, irq=1 and so=0.
- R2: mode_cpol takes the value of cpol_strap on the first clock after reset is released. Later changes of the strap leave it unchanged.
- R3: With mode_cpol=0, SCK idles low. SI is sampled on the falling SCK edge and SO changes after the rising edge.
- R4: With mode_cpol=1, SCK idles high. SI is sampled on the rising SCK edge and SO changes after the falling edge.
- R5: ss_n is active low. The MSB of the transmit byte appears on SO as soon as ss_n asserts. The following bits follow MSB first, one per drive edge that comes after a sample edge. SO is 0 while ss_n is high.
- R6: After eight sample edges, the assembled byte (first bit in bit 7) is placed on rx_data and rx_full is set. A one-cycle rd_en pulse clears rx_full.
- R7: A tx_wr pulse loads tx_data and clears tx_empty. Each byte start sets tx_empty again. A byte starts either when ss_n asserts or on the first drive edge after a completed byte.
- R8: If a byte completes while rx_full is still set, overrun is set and stays set. The new byte replaces the old one.
- R9: If a byte starts while tx_empty is set, the previous transmit value is sent again and underrun is set and stays set.
- R10: If ss_n deasserts before the eighth sample edge, the partial byte is discarded, rx_full is unaffected and the bit count restarts at the next frame.
- R11: SCK edges while ss_n is high change neither the received data, nor the flags, nor SO.
- R12: A one-cycle flag_clr pulse clears overrun and underrun.
- R13: irq is 1 exactly when at least one of rx_full, tx_empty, overrun or underrun is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol_strap | input | 1 | Polarity strap, captured after reset |
| sck | input | 1 | Serial clock from host |
| ss_n | input | 1 | Slave select, active low |
| si | input | 1 | Serial data from host |
| so | output | 1 | Serial data to host |
| rd_en | input | 1 | Processor read strobe for received byte |
| rx_data | output | 8 | Last received byte |
| tx_wr | input | 1 | Processor write strobe for transmit byte |
| tx_data | input | 8 | Byte to load into the transmit register |
| flag_clr | input | 1 | Clears the sticky error flags |
| mode_cpol | output | 1 | Captured clock polarity |
| rx_full | output | 1 | Received byte waiting |
| tx_empty | output | 1 | Transmit register free for a new byte |
| overrun | output | 1 | Sticky receive overrun |
| underrun | output | 1 | Sticky transmit underrun |
| irq | output | 1 | Interrupt to the processor |

## Verification
The assertions assume that each SCK level lasts at least four system clocks, so that every edge survives synchronisation. They also assume that ss_n changes only while SCK rests at its idle level, and that the processor never pulses tx_wr on the same cycle that a byte starts. The stimulus holds every SCK phase for eight clocks and toggles ss_n only with SCK idle. It writes and reads the registers only between bytes. SI is deliberately driven to the wrong value across each drive edge and corrected mid-phase, so that sampling on the wrong edge shows up as corrupt data.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  // Per-cycle events derived from the synchronised serial pins
  typedef struct packed {
    logic act;    // slave select asserted
    logic start;  // slave select just asserted
    logic smp;    // sample edge of SCK while selected
    logic drv;    // drive edge of SCK while selected
  } pin_evt_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
        else        chain_q <= {chain_q[STAGES-2:0], d[g]};
      end
      assign q[g] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_edge.sv
module spi_edge
  import spi_slv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sck_s,
  input  logic     ss_n_s,
  input  logic     cpol,
  output pin_evt_t evt
);
  logic sck_d_q, act_d_q;
  logic rise, fall, act;

  assign act  = ~ss_n_s;
  assign rise = sck_s & ~sck_d_q;
  assign fall = ~sck_s & sck_d_q;

  always_comb begin
    evt.act   = act;
    evt.start = act & ~act_d_q;
    evt.smp   = act & (cpol ? rise : fall);
    evt.drv   = act & (cpol ? fall : rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d_q <= 1'b0;
      act_d_q <= 1'b0;
    end else begin
      sck_d_q <= sck_s;
      act_d_q <= act;
    end
  end
endmodule

// File: rtl/spi_shift.sv
module spi_shift
  import spi_slv_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pin_evt_t      evt,
  input  logic          si_s,
  input  logic [DW-1:0] tx_word,
  output logic          so_bit,
  output logic          byte_done,
  output logic          byte_start,
  output logic [DW-1:0] rx_word,
  output logic [CW-1:0] bit_cnt
);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] rsh_q, rsh_n, tsh_q, tsh_n;
  logic          pend_q, pend_n;
  logic          shift_en, reload_en;

  assign reload_en  = evt.drv & pend_q & (cnt_q == '0);
  assign shift_en   = evt.drv & pend_q & (cnt_q != '0);
  assign byte_start = evt.start | reload_en;
  assign byte_done  = evt.smp & (cnt_q == LAST);
  assign rx_word    = {rsh_q[DW-2:0], si_s};
  assign so_bit     = evt.act & tsh_q[DW-1];
  assign bit_cnt    = cnt_q;

  always_comb begin
    cnt_n  = cnt_q;
    rsh_n  = rsh_q;
    tsh_n  = tsh_q;
    pend_n = pend_q;
    if (!evt.act) begin
      cnt_n  = '0;
      pend_n = 1'b0;
    end else begin
      if (evt.smp) begin
        rsh_n  = {rsh_q[DW-2:0], si_s};
        cnt_n  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        pend_n = 1'b1;
      end
      if (evt.drv) pend_n = 1'b0;
      if (byte_start)    tsh_n = tx_word;
      else if (shift_en) tsh_n = {tsh_q[DW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rsh_q  <= '0;
      tsh_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      rsh_q  <= rsh_n;
      tsh_q  <= tsh_n;
      pend_q <= pend_n;
    end
  end
endmodule

// File: rtl/spi_flags.sv
module spi_flags #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_done,
  input  logic [DW-1:0] rx_word,
  input  logic          byte_start,
  input  logic          rd_en,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_din,
  input  logic          flag_clr,
  output logic [DW-1:0] rx_q,
  output logic          rx_full,
  output logic [DW-1:0] tx_word,
  output logic          tx_empty,
  output logic          ovr,
  output logic          udr
);
  logic [DW-1:0] rx_r, rx_n, tx_r, tx_n;
  logic          full_q, full_n, txv_q, txv_n;
  logic          ovr_q, ovr_n, udr_q, udr_n;

  always_comb begin
    rx_n   = rx_r;
    full_n = full_q;
    ovr_n  = flag_clr ? 1'b0 : ovr_q;
    if (rd_en) full_n = 1'b0;
    if (byte_done) begin
      rx_n   = rx_word;
      full_n = 1'b1;
      if (full_q && !rd_en) ovr_n = 1'b1;
    end
  end

  always_comb begin
    tx_n  = tx_r;
    txv_n = txv_q;
    udr_n = flag_clr ? 1'b0 : udr_q;
    if (byte_start) begin
      txv_n = 1'b0;
      if (!txv_q) udr_n = 1'b1;
    end
    if (tx_wr) begin
      tx_n  = tx_din;
      txv_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_r   <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      tx_r   <= '0;
      txv_q  <= 1'b0;
      udr_q  <= 1'b0;
    end else begin
      rx_r   <= rx_n;
      full_q <= full_n;
      ovr_q  <= ovr_n;
      tx_r   <= tx_n;
      txv_q  <= txv_n;
      udr_q  <= udr_n;
    end
  end

  assign rx_q     = rx_r;
  assign rx_full  = full_q;
  assign tx_word  = tx_r;
  assign tx_empty = ~txv_q;
  assign ovr      = ovr_q;
  assign udr      = udr_q;
endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave
  import spi_slv_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpol_strap,
  input  logic          sck,
  input  logic          ss_n,
  input  logic          si,
  output logic          so,
  input  logic          rd_en,
  output logic [DW-1:0] rx_data,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_data,
  input  logic          flag_clr,
  output logic          mode_cpol,
  output logic          rx_full,
  output logic          tx_empty,
  output logic          overrun,
  output logic          underrun,
  output logic          irq
);
  localparam int CW = $clog2(DW);

  logic [2:0]    pins_s;
  pin_evt_t      evt;
  logic          byte_done, byte_start;
  logic [DW-1:0] rx_word, tx_word;
  logic [CW-1:0] bit_cnt;
  logic          cpol_q, cpol_n, strap_done_q, strap_done_n;

  // bit 0 sck, bit 1 ss_n, bit 2 si
  spi_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({si, ss_n, sck}), .q(pins_s)
  );

  always_comb begin
    cpol_n       = cpol_q;
    strap_done_n = 1'b1;
    if (!strap_done_q) cpol_n = cpol_strap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpol_q       <= 1'b0;
      strap_done_q <= 1'b0;
    end else begin
      cpol_q       <= cpol_n;
      strap_done_q <= strap_done_n;
    end
  end

  spi_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sck_s(pins_s[0]), .ss_n_s(pins_s[1]),
    .cpol(cpol_q), .evt(evt)
  );

  spi_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .evt(evt), .si_s(pins_s[2]),
    .tx_word(tx_word), .so_bit(so), .byte_done(byte_done),
    .byte_start(byte_start), .rx_word(rx_word), .bit_cnt(bit_cnt)
  );

  spi_flags #(.DW(DW)) u_flags (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .rx_word(rx_word),
    .byte_start(byte_start), .rd_en(rd_en), .tx_wr(tx_wr), .tx_din(tx_data),
    .flag_clr(flag_clr), .rx_q(rx_data), .rx_full(rx_full), .tx_word(tx_word),
    .tx_empty(tx_empty), .ovr(overrun), .udr(underrun)
  );

  assign mode_cpol = cpol_q;
  assign irq       = rx_full | tx_empty | overrun | underrun;
endmodule

// File: rtl/spi_byte_slave_chk.sv
module spi_byte_slave_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ss_act,
  input logic          so,
  input logic          irq,
  input logic          rx_full,
  input logic          tx_empty,
  input logic          overrun,
  input logic          underrun,
  input logic          flag_clr,
  input logic          tx_wr,
  input logic          rd_en,
  input logic          byte_done,
  input logic [CW-1:0] bit_cnt,
  input logic          mode_cpol,
  input logic          strap_done
);
  AST_SO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_act |-> !so); // R5
  AST_IRQ_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full || tx_empty) |-> irq); // R13
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !flag_clr) |=> overrun); // R8
  AST_UDR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !flag_clr) |=> underrun); // R9
  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !byte_done && !tx_wr && !ss_act) |=> (!overrun && !underrun)); // R12
  AST_CPOL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done && $past(strap_done)) |-> $stable(mode_cpol)); // R2
  AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> !tx_empty); // R7
  AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> rx_full); // R6
  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !byte_done) |=> !rx_full); // R6
  AST_ABORT_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_act |=> (bit_cnt == '0)); // R10
endmodule

bind spi_byte_slave spi_byte_slave_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ss_act(evt.act), .so(so), .irq(irq),
  .rx_full(rx_full), .tx_empty(tx_empty), .overrun(overrun),
  .underrun(underrun), .flag_clr(flag_clr), .tx_wr(tx_wr), .rd_en(rd_en),
  .byte_done(byte_done), .bit_cnt(bit_cnt), .mode_cpol(mode_cpol),
  .strap_done(strap_done_q)
);

// File: tb/sim_spi_byte_slave.sv
module sim_spi_byte_slave;
  localparam int H = 8;

  logic clk, rst_n, cpol_strap, sck, ss_n, si, so;
  logic rd_en, tx_wr, flag_clr;
  logic [7:0] rx_data, tx_data;
  logic mode_cpol, rx_full, tx_empty, overrun, underrun, irq;

  int checks, errors;
  logic tb_cpol;
  bit   done;

  spi_byte_slave u0 (
    .clk(clk), .rst_n(rst_n), .cpol_strap(cpol_strap), .sck(sck), .ss_n(ss_n),
    .si(si), .so(so), .rd_en(rd_en), .rx_data(rx_data), .tx_wr(tx_wr),
    .tx_data(tx_data), .flag_clr(flag_clr), .mode_cpol(mode_cpol),
    .rx_full(rx_full), .tx_empty(tx_empty), .overrun(overrun),
    .underrun(underrun), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0; cpol_strap = strap; tb_cpol = strap; sck = strap;
    ss_n = 1'b1; si = 1'b0; rd_en = 0; tx_wr = 0; flag_clr = 0; tx_data = '0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic pulse_wr(input logic [7:0] v);
    tx_data = v; tx_wr = 1'b1; wait_clk(1); tx_wr = 1'b0; wait_clk(2);
  endtask
  task automatic pulse_rd;
    rd_en = 1'b1; wait_clk(1); rd_en = 1'b0; wait_clk(2);
  endtask
  task automatic pulse_clr;
    flag_clr = 1'b1; wait_clk(1); flag_clr = 1'b0; wait_clk(2);
  endtask

  task automatic frame_on;  ss_n = 1'b0; wait_clk(H); endtask
  task automatic frame_off; ss_n = 1'b1; wait_clk(H); endtask

  // SI holds the wrong value across the drive edge, the correct one across the sample edge
  task automatic xfer_bits(input logic [7:0] out, input int n, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      si = ~out[7-i];
      wait_clk(H);
      sck = ~tb_cpol;
      wait_clk(H/2);
      si = out[7-i];
      wait_clk(H/2);
      got[7-i] = so;
      sck = tb_cpol;
      wait_clk(H);
    end
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    check("R1 rx_full", rx_full, 0);
    check("R1 tx_empty", tx_empty, 1);
    check("R1 overrun", overrun, 0);
    check("R1 underrun", underrun, 0);
    check("R1 irq", irq, 1);
    check("R1 so", so, 0);
    check("R2 cpol0", mode_cpol, 0);
  endtask

  task automatic t_basic;
    logic [7:0] g;
    pulse_wr(8'hA5);
    check("R7 tx_empty after write", tx_empty, 0);
    ss_n = 1'b0; wait_clk(5);
    check("R5 msb on select", so, 1);
    wait_clk(H-5);
    xfer_bits(8'h3C, 8, g);
    frame_off;
    check("R3 R5 so byte", g, 8'hA5);
    check("R3 R6 rx byte", rx_data, 8'h3C);
    check("R6 rx_full", rx_full, 1);
    check("R7 tx_empty after start", tx_empty, 1);
    check("R5 so idle", so, 0);
    pulse_rd;
    check("R6 read clears", rx_full, 0);
  endtask

  task automatic t_multi;
    logic [7:0] g1, g2;
    pulse_wr(8'h81);
    frame_on;
    xfer_bits(8'h5A, 8, g1);
    check("R6 first rx", rx_data, 8'h5A);
    pulse_rd;
    pulse_wr(8'h7E);
    xfer_bits(8'hC3, 8, g2);
    frame_off;
    check("R5 first tx", g1, 8'h81);
    check("R7 second tx", g2, 8'h7E);
    check("R6 second rx", rx_data, 8'hC3);
    check("R8 no overrun", overrun, 0);
    check("R9 no underrun", underrun, 0);
    pulse_rd;
  endtask

  task automatic t_overrun;
    logic [7:0] g1, g2;
    pulse_wr(8'h11);
    frame_on;
    xfer_bits(8'h22, 8, g1);
    pulse_wr(8'h33);
    xfer_bits(8'h44, 8, g2);
    frame_off;
    check("R8 overrun set", overrun, 1);
    check("R8 newest kept", rx_data, 8'h44);
    check("R8 tx ok", {g1, g2}, 16'h1133);
    check("R13 irq on overrun", irq, 1);
    pulse_rd;
    wait_clk(H);
    check("R8 sticky", overrun, 1);
    pulse_clr;
    check("R12 overrun cleared", overrun, 0);
  endtask

  task automatic t_underrun;
    logic [7:0] g;
    frame_on;
    xfer_bits(8'h55, 8, g);
    frame_off;
    check("R9 repeat value", g, 8'h33);
    check("R9 underrun set", underrun, 1);
    pulse_rd;
    pulse_clr;
    check("R12 underrun cleared", underrun, 0);
    check("R13 irq on tx_empty", irq, 1);
    pulse_wr(8'h96);
    check("R13 irq low", irq, 0);
  endtask

  task automatic t_abort;
    logic [7:0] g;
    frame_on;
    xfer_bits(8'hE7, 4, g);
    frame_off;
    check("R10 partial dropped", rx_full, 0);
    pulse_wr(8'h69);
    frame_on;
    xfer_bits(8'hF0, 8, g);
    frame_off;
    check("R10 realigned rx", rx_data, 8'hF0);
    check("R10 realigned tx", g, 8'h69);
    pulse_rd;
  endtask

  task automatic t_idle_edges;
    pulse_wr(8'h3A);
    for (int i = 0; i < 5; i++) begin
      si = i[0];
      sck = ~tb_cpol; wait_clk(H);
      sck = tb_cpol;  wait_clk(H);
    end
    check("R11 rx_full", rx_full, 0);
    check("R11 so", so, 0);
    check("R11 tx_empty", tx_empty, 0);
    check("R11 underrun", underrun, 0);
  endtask

  task automatic t_cpol1;
    logic [7:0] g;
    do_reset(1'b1);
    check("R2 cpol1", mode_cpol, 1);
    cpol_strap = 1'b0;
    wait_clk(4);
    check("R2 strap ignored", mode_cpol, 1);
    pulse_wr(8'hC6);
    frame_on;
    xfer_bits(8'h9B, 8, g);
    frame_off;
    check("R4 so byte", g, 8'hC6);
    check("R4 rx byte", rx_data, 8'h9B);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    t_reset;
    t_basic;
    t_multi;
    t_overrun;
    t_underrun;
    t_abort;
    t_idle_edges;
    t_cpol1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule